// File: doc/BRIEF.md
# Blocking Write-Back Data Cache Controller

This block is a direct-mapped data cache placed between a processor load/store port and a slower memory that moves whole cache lines. Each line holds four 32-bit words (16 bytes). The default geometry has 1024 lines, for 16 KB in total. Each line has its own tag, a valid flag and a dirty flag. Stores update only the cache, and a line reaches memory only when it is evicted. A store miss first fetches the line and then merges the stored word into it.

Only one request is served at a time. The processor raises its request strobe and holds the request steady until the ready output pulses, and the controller performs all memory traffic in the meantime. A four-state sequencer drives the work: waiting, tag compare, write-back of a dirty victim, and line fetch. After a fetch it always returns to tag compare, so the retried access completes as a hit. The memory side takes any number of cycles per line transfer and signals completion with a one-cycle ready pulse.

Top module: `wb_cache_ctrl`

## Requirements
- R1: A 32-bit byte address is split into offset bits [OFFSET_W-1:0], index bits [OFFSET_W+INDEX_W-1:OFFSET_W] and tag bits above them. The default is OFFSET_W=4 and INDEX_W=10, so the tag is 18 bits. Every memory address that the block issues has its offset bits at zero.
- R2: After reset every line is invalid, and cpu_ready and mem_valid are low.
- R3: A read hit raises cpu_ready one clock after the clock edge at which the request was first sampled. cpu_rdata then carries word addr[3:2] of the line.
- R4: A write hit replaces word addr[3:2] of the line and leaves the other words unchanged. Address bits [1:0] have no effect. The line becomes dirty, and there is no memory traffic.
- R5: A miss whose line is invalid or clean issues one memory read at {tag, index, 0000} and no memory write. The cycle after mem_ready, the access is retried and hits. The total latency is 2 + L clocks for a memory that responds in L clocks.
- R6: A miss on a valid dirty line first writes the whole old line to {old tag, index, 0000}, then fetches the new line. The total latency is 3 + 2L clocks.
- R7: A write miss fetches the line and then merges the stored word into it (write allocate).
- R8: While a memory request is waiting for mem_ready, mem_valid stays high, mem_addr stays stable and cpu_ready stays low.
- R9: Word k of a 128-bit line sits at bits [32k+31:32k] in both mem_wdata and mem_rdata.
- R10: A freshly fetched line is clean, so evicting it later without a store causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Request strobe, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory line request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Line returned by memory |
| mem_ready | input | 1 | One-cycle transfer completion pulse |

## Verification
A corrupted tag or valid flag shows up on the very next access to that index. Either the latency is wrong (one clock instead of 2 + L, or the reverse) or an unexpected memory read appears. A lost or spurious dirty flag stays hidden until the line is evicted. It then shows up as a missing or extra write-back, or as stale line contents in memory, which the reads after the eviction expose as wrong load data. A bad word select or merge shows up as a wrong load value on the first read of the affected word. Running a small four-line configuration over many addresses forces evictions often, so every such fault surfaces within a few accesses.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int AW = 32;
  localparam int WW = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMP   = 2'd1,
    ST_WB    = 2'd2,
    ST_ALLOC = 2'd3
  } ctl_state_t;

  // extract w bits of a starting at bit lsb (w < 32)
  function automatic logic [AW-1:0] addr_field(input logic [AW-1:0] a, input int lsb, input int w);
    return (a >> lsb) & ((32'd1 << w) - 32'd1);
  endfunction

  // rebuild a line-aligned address from tag and index
  function automatic logic [AW-1:0] line_addr(input logic [AW-1:0] tag, input logic [AW-1:0] idx,
                                              input int idx_w, input int off_w);
    return ((tag << idx_w) | idx) << off_w;
  endfunction
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx_i,
  input  logic               fill_i,
  input  logic [TAG_W-1:0]   fill_tag_i,
  input  logic               mark_dirty_i,
  output logic               valid_o,
  output logic               dirty_o,
  output logic [TAG_W-1:0]   tag_o
);
  localparam int LINES = 1 << INDEX_W;

  logic             valid_q [LINES];
  logic             dirty_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_i) tag_q[idx_i] <= fill_tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];

  // R4: a store hit leaves the line dirty
  a_r4_store_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_dirty_i && !fill_i) |=> dirty_q[$past(idx_i)]);
  // R10: a filled line starts clean
  a_r10_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |=> (valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]));
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int INDEX_W = 10,
  parameter int LINE_W  = 128,
  parameter int WORD_W  = 32,
  parameter int WSEL_W  = 2
) (
  input  logic               clk,
  input  logic [INDEX_W-1:0] idx_i,
  input  logic [WSEL_W-1:0]  wsel_i,
  input  logic               fill_i,
  input  logic [LINE_W-1:0]  fill_line_i,
  input  logic               word_wr_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [LINE_W-1:0]  line_o,
  output logic [WORD_W-1:0]  word_o
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (fill_i)         line_q[idx_i] <= fill_line_i;
    else if (word_wr_i) line_q[idx_i][wsel_i*WORD_W +: WORD_W] <= word_i;
  end

  assign line_o = line_q[idx_i];
  assign word_o = line_o[wsel_i*WORD_W +: WORD_W];
endmodule

// File: rtl/cache_fsm.sv
module cache_fsm
  import cache_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_valid,
  input  logic       hit_i,
  input  logic       victim_dirty_i,
  input  logic       mem_ready,
  output ctl_state_t state_o
);
  ctl_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (cpu_valid) st_d = ST_CMP;
      ST_CMP:   if (hit_i) st_d = ST_IDLE;
                else if (victim_dirty_i) st_d = ST_WB;
                else st_d = ST_ALLOC;
      ST_WB:    if (mem_ready) st_d = ST_ALLOC;
      ST_ALLOC: if (mem_ready) st_d = ST_CMP;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R6: a miss on a dirty victim starts with a write-back
  a_r6_dirty_miss_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMP && !hit_i && victim_dirty_i) |=> st_q == ST_WB);
  // R5: a miss on a clean or invalid line fetches at once
  a_r5_clean_miss_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMP && !hit_i && !victim_dirty_i) |=> st_q == ST_ALLOC);
  // R6: after the write-back the fetch follows
  a_r6_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WB && mem_ready) |=> st_q == ST_ALLOC);
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import cache_pkg::*;
#(
  parameter int INDEX_W  = 10,
  parameter int OFFSET_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_valid,
  input  logic                 cpu_we,
  input  logic [31:0]          cpu_addr,
  input  logic [31:0]          cpu_wdata,
  output logic [31:0]          cpu_rdata,
  output logic                 cpu_ready,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [31:0]          mem_addr,
  output logic [(8<<OFFSET_W)-1:0] mem_wdata,
  input  logic [(8<<OFFSET_W)-1:0] mem_rdata,
  input  logic                 mem_ready
);
  localparam int TAG_W  = AW - INDEX_W - OFFSET_W;
  localparam int LINE_W = 8 << OFFSET_W;
  localparam int WORDS  = LINE_W / WW;
  localparam int WSEL_W = $clog2(WORDS);

  ctl_state_t         st;
  logic [TAG_W-1:0]   req_tag, line_tag;
  logic [INDEX_W-1:0] req_idx;
  logic [WSEL_W-1:0]  req_wsel;
  logic               line_valid, line_dirty;
  logic               hit_w, victim_dirty_w, fill_w, store_hit_w;
  logic [LINE_W-1:0]  line_w;

  assign req_tag  = TAG_W'(addr_field(cpu_addr, OFFSET_W + INDEX_W, TAG_W));
  assign req_idx  = INDEX_W'(addr_field(cpu_addr, OFFSET_W, INDEX_W));
  assign req_wsel = WSEL_W'(addr_field(cpu_addr, OFFSET_W - WSEL_W, WSEL_W));

  assign hit_w          = line_valid && (line_tag == req_tag);
  assign victim_dirty_w = line_valid && line_dirty;
  assign fill_w         = (st == ST_ALLOC) && mem_ready;
  assign store_hit_w    = (st == ST_CMP) && hit_w && cpu_we;

  cache_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .hit_i(hit_w),
    .victim_dirty_i(victim_dirty_w), .mem_ready(mem_ready), .state_o(st)
  );

  cache_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx_i(req_idx), .fill_i(fill_w),
    .fill_tag_i(req_tag), .mark_dirty_i(store_hit_w),
    .valid_o(line_valid), .dirty_o(line_dirty), .tag_o(line_tag)
  );

  cache_data_store #(.INDEX_W(INDEX_W), .LINE_W(LINE_W), .WORD_W(WW), .WSEL_W(WSEL_W)) u_data (
    .clk(clk), .idx_i(req_idx), .wsel_i(req_wsel), .fill_i(fill_w),
    .fill_line_i(mem_rdata), .word_wr_i(store_hit_w), .word_i(cpu_wdata),
    .line_o(line_w), .word_o(cpu_rdata)
  );

  assign cpu_ready = (st == ST_CMP) && hit_w;
  assign mem_valid = (st == ST_WB) || (st == ST_ALLOC);
  assign mem_we    = (st == ST_WB);
  assign mem_wdata = line_w;
  assign mem_addr  = (st == ST_WB)
                   ? line_addr(AW'(line_tag), AW'(req_idx), INDEX_W, OFFSET_W)
                   : line_addr(AW'(req_tag),  AW'(req_idx), INDEX_W, OFFSET_W);

  // R1: memory addresses are line aligned
  a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[OFFSET_W-1:0] == '0));
  // R6: write-back goes to the line of the current index
  a_r6_wb_index: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr[OFFSET_W +: INDEX_W] == req_idx));
  // R5: after a fetch the retried access hits
  a_r5_fetch_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_w |=> (st == ST_CMP && hit_w));
  // R8: request held stable until memory answers, no completion meanwhile
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  a_r8_no_ready_in_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cpu_ready);
endmodule

// File: tb/sim_wb_cache_ctrl.sv
module sim_wb_cache_ctrl;
  localparam int IDXW = 2;
  localparam int LAT  = 3;
  localparam int NBLK = 64;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic cpu_ready, mem_valid, mem_we, mem_ready = 0;
  logic [31:0] mem_addr;
  logic [127:0] mem_wdata, mem_rdata = 0;

  int errors = 0, checks = 0;
  int wb_n = 0, rd_n = 0;
  logic [31:0] wb_addr = 0, rd_addr = 0;
  logic [31:0] mem_words [NBLK*4];
  logic [31:0] gold [NBLK*4];
  logic        ref_v [4];
  logic        ref_d [4];
  logic [3:0]  ref_t [4];

  always #2.5 clk = ~clk;

  wb_cache_ctrl #(.INDEX_W(IDXW), .OFFSET_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  function automatic logic [31:0] init_word(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: completes after LAT cycles, word k at bits 32k+31:32k (R9)
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 0;
        cnt = 0;
      end else if (mem_valid) begin
        cnt++;
        if (cnt == LAT) begin
          mem_ready = 1;
          if (mem_we) begin
            for (int k = 0; k < 4; k++) mem_words[mem_addr[9:4]*4 + k] = mem_wdata[32*k +: 32];
            wb_n++;
            wb_addr = mem_addr;
          end else begin
            for (int k = 0; k < 4; k++) mem_rdata[32*k +: 32] = mem_words[mem_addr[9:4]*4 + k];
            rd_n++;
            rd_addr = mem_addr;
          end
        end
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd);
    int cyc, wb0, rd0, exp_cyc, oi;
    logic [1:0] idx;
    logic [3:0] tg;
    logic hit, dwb;
    logic [31:0] rd;
    idx = addr[5:4];
    tg  = addr[9:6];
    hit = ref_v[idx] && ref_t[idx] == tg;
    dwb = !hit && ref_v[idx] && ref_d[idx];
    oi  = {ref_t[idx], idx};
    exp_cyc = hit ? 1 : (dwb ? 3 + 2*LAT : 2 + LAT);
    wb0 = wb_n;
    rd0 = rd_n;
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cpu_ready || cyc > 200) break;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1 cpu_valid = 0;
    chk(cyc == exp_cyc, hit ? "R3" : (dwb ? "R6" : "R5"), "latency", cyc, exp_cyc);
    chk(rd_n - rd0 == (hit ? 0 : 1), hit ? "R4" : "R5", "fetch count", rd_n - rd0, hit ? 0 : 1);
    chk(wb_n - wb0 == (dwb ? 1 : 0), dwb ? "R6" : "R10", "write-back count", wb_n - wb0, dwb ? 1 : 0);
    if (!hit) chk(rd_addr == {22'b0, addr[9:4], 4'b0}, "R1", "fetch address", rd_addr, {22'b0, addr[9:4], 4'b0});
    if (dwb) begin
      chk(wb_addr == 32'(oi) << 4, "R6", "write-back address", wb_addr, 32'(oi) << 4);
      for (int k = 0; k < 4; k++)
        chk(mem_words[oi*4+k] == gold[oi*4+k], "R9", "written-back word", mem_words[oi*4+k], gold[oi*4+k]);
    end
    if (!we) chk(rd == gold[addr[9:2]], hit ? "R3" : "R7", "load data", rd, gold[addr[9:2]]);
    if (!hit) begin ref_v[idx] = 1; ref_t[idx] = tg; ref_d[idx] = 0; end
    if (we) begin ref_d[idx] = 1; gold[addr[9:2]] = wd; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < NBLK*4; i++) begin mem_words[i] = init_word(i); gold[i] = init_word(i); end
    for (int i = 0; i < 4; i++) begin ref_v[i] = 0; ref_d[i] = 0; ref_t[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(cpu_ready == 0, "R2", "cpu_ready in reset", 32'(cpu_ready), 0);
    chk(mem_valid == 0, "R2", "mem_valid in reset", 32'(mem_valid), 0);
    rst_n = 1;
    // R5/R10: clean fetches and clean evictions
    for (int b = 0; b < 8; b++) access(0, 32'(b) << 4, 0);
    // R7/R6/R4: stores over 16 lines, byte offset bits varied
    for (int w = 0; w < 64; w++) access(1, (32'(w) << 2) | 32'(w & 3), 32'hC0DE0000 + 32'(w));
    // R3: read back every word of every line
    for (int w = 0; w < NBLK*4; w++) access(0, (32'(w) << 2) | 32'((w >> 3) & 3), 0);
    // R4: store hit then load of the same word, neighbours untouched
    access(0, 32'h40, 0);
    access(1, 32'h47, 32'hFEEDBEEF);
    access(0, 32'h44, 0);
    access(0, 32'h48, 0);
    // mixed pattern
    lcg = 32'h1234567;
    for (int n = 0; n < 400; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      access(lcg[31], {22'b0, lcg[17:10]} << 2 | 32'(lcg[1:0]), lcg ^ 32'hA5A5A5A5);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule